// File: doc/BRIEF.md
# Line Event Timestamping Engine

This block watches a bank of input lines, such as GPIO pins or on-chip interrupt lines, for changes of level. Every line passes through a two-flop synchroniser. A change on a line whose enable bit is set captures the value of a shared free-running system counter and the new level of that line. The change then waits in a per-line pending bit until a small scheduler pushes it into an internal FIFO. Each FIFO record holds the 64-bit counter value, the line index and the new level.

Software sees the block through a simple register port with separate write and read strobes. Line enables sit in 32-bit slice registers. A threshold register sets the FIFO occupancy at which the interrupt output rises. A sticky overflow flag records events that were dropped because the FIFO was full. Reading the info register pops the oldest record.

The scheduler has two states. PK_IDLE means no event is pending. PK_DRAIN means at least one event is pending. The transition IDLE to DRAIN happens when a detected change sets a pending bit. DRAIN to DRAIN happens while pending bits remain after the current push. DRAIN to IDLE happens when the last pending bit clears, either by a push or because its line was disabled. In PK_DRAIN the lowest pending enabled line is pushed, one per cycle.

Top module: `line_ts_engine`

## Requirements
- R1: A level change on an enabled line produces one record. Its timestamp equals the system counter value sampled at the third rising clock edge after the input changed (two synchroniser stages and one detect stage). Its level bit is the new level, 1 meaning high.
- R2: Line 32*s+b is enabled by bit b of the slice register at address s (s from 0 to NUM_SLICES-1). A change on a line whose bit is 0 produces no record.
- R3: Changes detected on several enabled lines in the same cycle are pushed one per cycle in ascending line index. All of them carry the same timestamp.
- R4: Clearing a line's enable bit discards that line's pending, not yet pushed event.
- R5: An event that arrives while the FIFO holds FIFO_DEPTH records is dropped, and bit 0 of address 0x21 becomes 1. The flag stays set until a write to 0x21 with bit 0 set clears it.
- R6: Address 0x24 returns bits 31:0 of the head timestamp and address 0x25 returns bits 63:32, without popping. A read strobe on address 0x26 returns the line index in bits 15:0 and the level in bit 16, and pops the head. When the FIFO is empty, 0x24, 0x25 and 0x26 read 0 and a read strobe pops nothing.
- R7: Address 0x22 returns the number of records currently held.
- R8: irq is 1 exactly when the occupancy is at least the threshold at address 0x20. The threshold resets to 1. A written value of 0 is stored as 1, and a value above 256 is stored as 256.
- R9: After reset the occupancy is 0, irq is 0, every slice register is 0 and the overflow flag is 0.
- R10: While a line's event is pending, further changes on that line are not recorded. The pushed record keeps the first timestamp and level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_in | input | NUM_SLICES*32 | Asynchronous monitored lines |
| sys_count | input | TS_W | Shared free-running system counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a strobe on 0x26 pops |
| rd_addr | input | 8 | Read address |
| rdata | output | 32 | Combinational read data for rd_addr |
| irq | output | 1 | Occupancy at or above the threshold |

## Verification
The bench builds the block with NUM_SLICES of 3 (96 lines) and FIFO_DEPTH of 8. The short FIFO lets a burst of twelve simultaneous line changes reach the full condition and the dropped-event flag within a few cycles. The 96 lines put the line index check across all three slice registers. Bursts of eight and more lines keep events pending for many cycles, which is long enough to disable a slice or re-toggle a line before its push.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam logic [7:0] ADDR_THRESH = 8'h20;
    localparam logic [7:0] ADDR_OVF    = 8'h21;
    localparam logic [7:0] ADDR_COUNT  = 8'h22;
    localparam logic [7:0] ADDR_TSLO   = 8'h24;
    localparam logic [7:0] ADDR_TSHI   = 8'h25;
    localparam logic [7:0] ADDR_INFO   = 8'h26;
    localparam int         SLICE_W     = 32;
    localparam int         THRESH_MAX  = 256;

    typedef enum logic {
        PK_IDLE  = 1'b0,
        PK_DRAIN = 1'b1
    } pick_state_e;
endpackage

// File: rtl/line_sync_detect.sv
module line_sync_detect #(
    parameter int N = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_in,
    output logic [N-1:0] chg,
    output logic [N-1:0] lvl
);
    logic [N-1:0] s1_q, s2_q, prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q[g]   <= 1'b0;
                s2_q[g]   <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                s1_q[g]   <= lines_in[g];
                s2_q[g]   <= s1_q[g];
                prev_q[g] <= s2_q[g];
            end
        end
        assign chg[g] = s2_q[g] ^ prev_q[g];
        assign lvl[g] = s2_q[g];
    end
endmodule

// File: rtl/line_event_picker.sv
module line_event_picker
    import ts_pkg::*;
#(
    parameter int N     = 96,
    parameter int TS_W  = 64,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     chg,
    input  logic [N-1:0]     lvl,
    input  logic [N-1:0]     en,
    input  logic [TS_W-1:0]  ts_in,
    output logic             push_vld,
    output logic [IDX_W-1:0] push_idx,
    output logic             push_lvl,
    output logic [TS_W-1:0]  push_ts
);
    pick_state_e      state_q, state_d;
    logic [N-1:0]     pend_q, pend_d, pend_eff, cap;
    logic [TS_W-1:0]  ts_q [N];
    logic [N-1:0]     lv_q;
    logic             found;
    logic [IDX_W-1:0] pick;

    // lowest pending enabled line wins
    always_comb begin
        pend_eff = pend_q & en;
        found    = 1'b0;
        pick     = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && pend_eff[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    // output process
    always_comb begin
        push_vld = 1'b0;
        unique case (state_q)
            PK_IDLE:  push_vld = 1'b0;
            PK_DRAIN: push_vld = found;
            default:  push_vld = 1'b0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cap[i] = en[i] && !pend_q[i] && chg[i];
            if (!en[i])
                pend_d[i] = 1'b0;
            else if (pend_q[i])
                pend_d[i] = !(push_vld && (pick == IDX_W'(i)));
            else
                pend_d[i] = chg[i];
        end
        state_d = (|pend_d) ? PK_DRAIN : PK_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (cap[i]) begin
                ts_q[i] <= ts_in;
                lv_q[i] <= lvl[i];
            end
        end
    end

    assign push_idx = pick;
    assign push_lvl = lv_q[pick];
    assign push_ts  = ts_q[pick];

    // R3: a pushed line no longer pends in the following cycle
    a_r3_push_clears: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |=> !pend_q[$past(push_idx)]);
    // R4: a line disabled in a cycle is not pending in the next one
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[push_idx] && pend_q[push_idx]) |=> !pend_q[$past(push_idx)]);
endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          dropped
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= din;
    end

    assign dout  = mem[rptr_q];
    assign count = cnt_q;

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R6: a pop strobe on an empty FIFO leaves it empty
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
    // R5: a push into a full FIFO without pop leaves it full
    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/line_ts_engine.sv
module line_ts_engine
    import ts_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int TS_W       = 64,
    parameter int FIFO_DEPTH = 256,
    localparam int NUM_LINES = NUM_SLICES * SLICE_W,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int REC_W     = TS_W + IDX_W + 1,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int SLW       = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic [TS_W-1:0]      sys_count,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [31:0]          wdata,
    input  logic                 rd_en,
    input  logic [7:0]           rd_addr,
    output logic [31:0]          rdata,
    output logic                 irq
);
    logic [SLICE_W-1:0]   en_q [NUM_SLICES];
    logic [NUM_LINES-1:0] en_flat;
    logic [8:0]           thresh_q;
    logic                 ovf_q;
    logic [NUM_LINES-1:0] chg, lvl;
    logic                 push_vld, push_lvl, fifo_empty, dropped, pop;
    logic [IDX_W-1:0]     push_idx;
    logic [TS_W-1:0]      push_ts;
    logic [REC_W-1:0]     head;
    logic [CW-1:0]        count;
    logic [TS_W-1:0]      hd_ts;
    logic [IDX_W-1:0]     hd_idx;
    logic                 hd_lvl;
    logic                 ovf_clr;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        assign en_flat[s*SLICE_W +: SLICE_W] = en_q[s];
    end

    line_sync_detect #(.N(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .chg(chg), .lvl(lvl)
    );

    line_event_picker #(.N(NUM_LINES), .TS_W(TS_W), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .chg(chg), .lvl(lvl), .en(en_flat),
        .ts_in(sys_count), .push_vld(push_vld), .push_idx(push_idx),
        .push_lvl(push_lvl), .push_ts(push_ts)
    );

    assign pop = rd_en && (rd_addr == ADDR_INFO);

    ts_record_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_vld),
        .din({push_ts, push_idx, push_lvl}), .pop(pop), .dout(head),
        .count(count), .empty(fifo_empty), .dropped(dropped)
    );

    assign hd_ts  = head[REC_W-1 -: TS_W];
    assign hd_idx = head[IDX_W:1];
    assign hd_lvl = head[0];
    assign ovf_clr = wr_en && (wr_addr == ADDR_OVF) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLICES; s++) en_q[s] <= '0;
            thresh_q <= 9'd1;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_en && (32'(wr_addr) < NUM_SLICES))
                en_q[wr_addr[SLW-1:0]] <= wdata;
            if (wr_en && (wr_addr == ADDR_THRESH)) begin
                if (wdata == '0)
                    thresh_q <= 9'd1;
                else if (wdata > 32'(THRESH_MAX))
                    thresh_q <= 9'(THRESH_MAX);
                else
                    thresh_q <= wdata[8:0];
            end
            if (dropped)      ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(rd_addr) < NUM_SLICES)
            rdata = en_q[rd_addr[SLW-1:0]];
        else if (rd_addr == ADDR_THRESH)
            rdata = 32'(thresh_q);
        else if (rd_addr == ADDR_OVF)
            rdata = 32'(ovf_q);
        else if (rd_addr == ADDR_COUNT)
            rdata = 32'(count);
        else if (!fifo_empty) begin
            if (rd_addr == ADDR_TSLO)      rdata = hd_ts[31:0];
            else if (rd_addr == ADDR_TSHI) rdata = 32'(hd_ts >> 32);
            else if (rd_addr == ADDR_INFO) rdata = {15'd0, hd_lvl, 16'(hd_idx)};
        end
    end

    assign irq = (32'(count) >= 32'(thresh_q));

    // R5: overflow flag holds until cleared by a write of 1
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);
    // R5: a dropped event raises the flag
    a_r5_ovf_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> ovf_q);
    // R8: threshold stays within 1..256
    a_r8_thresh_range: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_q >= 9'd1) && (thresh_q <= 9'(THRESH_MAX)));
endmodule

// File: tb/test_line_ts_engine.sv
module test_line_ts_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NSL   = 3;
    localparam int NL    = NSL * 32;
    localparam int DEPTH = 8;
    localparam logic [7:0] A_TH = 8'h20, A_OVF = 8'h21, A_CNT = 8'h22,
                           A_LO = 8'h24, A_HI = 8'h25, A_INFO = 8'h26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lines = '0;
    logic [63:0]   sys_count = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    wr_addr = '0, rd_addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int  n_chk = 0, n_bad = 0;
    bit  mon_on = 1'b0;
    logic [63:0] q_ts[$];
    int          q_idx[$];
    bit          q_lvl[$];

    line_ts_engine #(.NUM_SLICES(NSL), .TS_W(64), .FIFO_DEPTH(DEPTH)) i_line_ts_engine (
        .clk(clk), .rst_n(rst_n), .lines_in(lines), .sys_count(sys_count),
        .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata), .rd_en(rd_en),
        .rd_addr(rd_addr), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) #1 sys_count <= sys_count + 1;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rec(int idx, bit lv, logic [63:0] ts);
        q_idx.push_back(idx); q_lvl.push_back(lv); q_ts.push_back(ts);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon_stop();
        mon_on = 1'b0;
        wait_cyc(3);
    endtask

    task automatic drain(string req);
        mon_on = 1'b1;
        for (int k = 0; k < 300 && q_idx.size() != 0; k++) @(negedge clk);
        wait_cyc(6);
        chk(req, 64'(q_idx.size()), 64'd0);
    endtask

    // scoreboard monitor
    initial begin
        logic [31:0] c, lo, hi, inf;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                rd(A_CNT, c);
                if (c != 0) begin
                    rd(A_LO, lo); rd(A_HI, hi); rd(A_INFO, inf);
                    rd_en = 1'b1;
                    if (q_idx.size() == 0) begin
                        chk("R2 unexpected record", 64'(inf), 64'hFFFF_FFFF);
                    end else begin
                        chk("R1 R3 idx", 64'(inf[15:0]), 64'(q_idx.pop_front()));
                        chk("R1 lvl", 64'(inf[16]), 64'(q_lvl.pop_front()));
                        chk("R1 ts", {hi, lo}, q_ts.pop_front());
                    end
                    @(negedge clk);
                    rd_en = 1'b0;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        logic [63:0] c0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        rd(A_CNT, d); chk("R9 count", 64'(d), 0);
        chk("R9 irq", 64'(irq), 0);
        rd(A_OVF, d); chk("R9 ovf", 64'(d), 0);
        rd(8'h01, d); chk("R9 enable", 64'(d), 0);
        rd(A_TH, d);  chk("R8 thresh reset", 64'(d), 1);

        // R2: disabled line is ignored
        lines[3] = 1'b1;
        wait_cyc(10);
        rd(A_CNT, d); chk("R2 disabled no record", 64'(d), 0);

        wr(8'h00, 32'h0000_00FF);
        wr(8'h02, 32'h0000_0020);
        mon_on = 1'b1;
        // R2: slice 2 bit 5 is line 69
        c0 = sys_count; lines[69] = 1'b1; expect_rec(69, 1, c0 + 2);
        wait_cyc(12);
        // R1: timestamp and levels
        c0 = sys_count; lines[2] = 1'b1; expect_rec(2, 1, c0 + 2);
        wait_cyc(12);
        c0 = sys_count; lines[2] = 1'b0; expect_rec(2, 0, c0 + 2);
        wait_cyc(12);
        // R2: line 10 not enabled
        lines[10] = 1'b1;
        wait_cyc(12);
        drain("R1 R2 drain");

        // R3 ascending order, R10 re-toggle while pending
        c0 = sys_count;
        for (int i = 0; i < 8; i++) begin
            lines[i] = ~lines[i];
            expect_rec(i, lines[i], c0 + 2);
        end
        @(negedge clk);
        lines[7] = ~lines[7];
        drain("R3 R10 drain");

        // R4: disable slice 1 while line 40 is still pending
        wr(8'h01, 32'hFFFF_FFFF);
        c0 = sys_count;
        for (int i = 0; i < 8; i++) begin
            lines[i] = ~lines[i];
            expect_rec(i, lines[i], c0 + 2);
        end
        lines[40] = 1'b1;
        wait_cyc(3);
        wr(8'h01, 32'h0);
        drain("R4 drain");
        wr(8'h01, 32'hFFFF_FFFF);
        wait_cyc(5);
        rd(A_CNT, d); chk("R4 no late record", 64'(d), 0);

        // R8 threshold clamp and irq
        mon_stop();
        wr(A_TH, 32'd0);   rd(A_TH, d); chk("R8 clamp low", 64'(d), 1);
        wr(A_TH, 32'd300); rd(A_TH, d); chk("R8 clamp high", 64'(d), 256);
        wr(A_TH, 32'd3);
        c0 = sys_count;
        for (int i = 0; i < 2; i++) begin
            lines[i] = ~lines[i];
            expect_rec(i, lines[i], c0 + 2);
        end
        wait_cyc(8);
        rd(A_CNT, d); chk("R7 count two", 64'(d), 2);
        chk("R8 irq below", 64'(irq), 0);
        c0 = sys_count; lines[2] = ~lines[2]; expect_rec(2, lines[2], c0 + 2);
        wait_cyc(8);
        rd(A_CNT, d); chk("R7 count three", 64'(d), 3);
        chk("R8 irq at threshold", 64'(irq), 1);
        drain("R8 drain");

        // R6 peek and pop
        mon_stop();
        c0 = sys_count; lines[4] = ~lines[4];
        wait_cyc(8);
        rd(A_LO, d); rd(A_HI, d2);
        chk("R6 peek ts", {d2, d}, c0 + 2);
        rd(A_CNT, d); chk("R6 peek no pop", 64'(d), 1);
        rd(A_INFO, d);
        chk("R6 info", 64'(d), 64'({15'd0, lines[4], 16'd4}));
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        rd(A_CNT, d); chk("R6 popped", 64'(d), 0);
        rd(A_INFO, d); chk("R6 empty info", 64'(d), 0);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        rd(A_CNT, d); chk("R6 empty pop", 64'(d), 0);

        // R5 overflow
        c0 = sys_count;
        for (int i = 32; i < 44; i++) lines[i] = ~lines[i];
        for (int i = 32; i < 40; i++) expect_rec(i, lines[i], c0 + 2);
        wait_cyc(20);
        rd(A_CNT, d); chk("R5 full count", 64'(d), DEPTH);
        rd(A_OVF, d); chk("R5 ovf set", 64'(d), 1);
        wr(A_OVF, 32'h0);
        rd(A_OVF, d); chk("R5 ovf sticky", 64'(d), 1);
        wr(A_OVF, 32'h1);
        rd(A_OVF, d); chk("R5 ovf cleared", 64'(d), 0);
        drain("R5 drain");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule